// File: doc/BRIEF.md
# UART-Emulating Host Register File

This block gives a host bus the register map of a classic PC serial-port UART. No serial engine sits behind it. A local processor services the registers through a second register port. Host software that expects a standard UART runs unchanged. Each host access becomes a handshake with the local controller instead of driving a shift register.

The host uses a chip select, one-cycle read and write strobes, a 3-bit offset and an 8-bit data bus. An external decoder matches the base address. When the host writes the transmit holding register, the block sets a "byte waiting" flag and pulses an interrupt toward the local side. When the local side reads that byte, the flag clears. When the local side writes a receive byte, the data-ready bit is set. When the host reads the receive buffer, that bit clears and the block pulses a "byte taken" flag toward the local side.

The local side also supplies:
- the upper line-status bits,
- the modem-status byte,
- the upper nibble of interrupt identification.

The local side can read back every register that the host writes. Both ports share one clock.

Top module: `uart_mimic_regs`

## Requirements
- R1: After reset, every stored register and flag is zero. A host read of offset 2 returns 0x01, and a host read of offset 5 returns 0x00.
- R2: Bit 7 of the line control register (offset 3) is the bank bit. When it is set, host offsets 0 and 1 reach the low and high divisor bytes. When it is clear, offset 0 reaches the receive/transmit byte and offset 1 reaches the interrupt enable register.
- R3: A host write to offset 0 with the bank bit clear stores the byte. On the next cycle the block sets `thrFull` and raises `locThrIrq` for exactly one cycle. A local read of local offset 0 returns the byte and clears `thrFull`.
- R4: A local write to local offset 0 stores a receive byte and sets line-status bit 0. A host read of offset 0 with the bank bit clear returns that byte. The read clears bit 0 and raises `locRbrTaken` for one cycle.
- R5: The low nibble of interrupt identification is 0x4 when enable bit 0 and data-ready are both set. Otherwise it is 0x2 when enable bit 1 is set and `thrFull` is clear. Otherwise it is 0x1. The upper nibble is the value the local side last wrote to bits 7:4 at local offset 3.
- R6: Without `hostCs`, host strobes change nothing and `hostRdata` is 0. `hostRdata` is also 0 whenever no selected host read is active.
- R7: Host writes to offsets 5 and 6 are ignored. Host line-status bits 7:1 come from local offset 1 writes, and local bit 0 is ignored. Host offset 6 returns the last byte written at local offset 2.
- R8: Scratch (host offset 7) and the divisor bytes hold any 8-bit value. The local side reads the following at the listed local offsets: interrupt enable at 1, FIFO control (host write offset 2) at 2, line control at 3, modem control (host offset 4) at 4, divisor low at 5, divisor high at 6, scratch at 7.
- R9: The interrupt enable register keeps only bits 3:0. Bits 7:4 read as 0.
- R10: If a flag is set and cleared in the same cycle, setting wins. This covers a local receive write together with a host receive read, and a host transmit write together with a local transmit read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| hostCs | input | 1 | Base address matched |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 3 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, combinational |
| locWr | input | 1 | Local write strobe |
| locRd | input | 1 | Local read strobe |
| locAddr | input | 3 | Local register offset |
| locWdata | input | 8 | Local write data |
| locRdata | output | 8 | Local read data, combinational |
| thrFull | output | 1 | Transmit byte waiting for the local side |
| locThrIrq | output | 1 | One-cycle pulse after a host transmit write |
| locRbrTaken | output | 1 | One-cycle pulse after a host receive read |

## Verification
The assertions check the following on every cycle:
- `thrFull` and data-ready change only in response to the strobe that should move them.
- The transmit interrupt pulse never appears without the flag.
- The line control register holds its value when no host write reaches it.

The interrupt priority order, the bank switch, and the value each offset returns can only be shown by the bench's scenarios. The same holds for the set-over-clear rule in a shared cycle and the ignored writes. The bench sweeps all 256 scratch values and every combination of enable bits, data-ready and `thrFull` against arithmetically computed expectations.

// File: rtl/mimic_pkg.sv
package mimic_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int IER_W  = 4;
  localparam int NIB_W  = DATA_W / 2;

  typedef struct packed {
    logic hostWrThr;
    logic hostWrDll;
    logic hostWrDlm;
    logic hostWrIer;
    logic hostWrFcr;
    logic hostWrLcr;
    logic hostWrMcr;
    logic hostWrScr;
    logic hostRdRbr;
    logic hostRdEn;
    logic locRdThr;
    logic locRdEn;
    logic locWrRbr;
    logic locWrLsr;
    logic locWrMsr;
    logic locWrIir;
  } strobe_t;
endpackage

// File: rtl/mimic_ctrl.sv
module mimic_ctrl
  import mimic_pkg::*;
(
  input  logic              hostCs,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              dlab,
  input  logic              locWr,
  input  logic              locRd,
  input  logic [ADDR_W-1:0] locAddr,
  output strobe_t           strb
);
  logic hWr, hRd;
  assign hWr = hostCs & hostWr;
  assign hRd = hostCs & hostRd;

  always_comb begin
    strb = '0;
    strb.hostRdEn = hRd;
    strb.locRdEn  = locRd;
    if (hWr) begin
      case (hostAddr)
        3'd0: if (dlab) strb.hostWrDll = 1'b1; else strb.hostWrThr = 1'b1;
        3'd1: if (dlab) strb.hostWrDlm = 1'b1; else strb.hostWrIer = 1'b1;
        3'd2: strb.hostWrFcr = 1'b1;
        3'd3: strb.hostWrLcr = 1'b1;
        3'd4: strb.hostWrMcr = 1'b1;
        3'd7: strb.hostWrScr = 1'b1;
        default: ;
      endcase
    end
    if (hRd && hostAddr == 3'd0 && !dlab) strb.hostRdRbr = 1'b1;
    if (locRd && locAddr == 3'd0) strb.locRdThr = 1'b1;
    if (locWr) begin
      case (locAddr)
        3'd0: strb.locWrRbr = 1'b1;
        3'd1: strb.locWrLsr = 1'b1;
        3'd2: strb.locWrMsr = 1'b1;
        3'd3: strb.locWrIir = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mimic_dp.sv
module mimic_dp
  import mimic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWdata,
  output logic              dlab,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] locRdata,
  output logic              thrFull,
  output logic              locThrIrq,
  output logic              locRbrTaken
);
  logic [DATA_W-1:0] rbr, thr, dll, dlm, fcr, lcr, mcr, scr, msr;
  logic [IER_W-1:0]  ier;
  logic [DATA_W-2:0] lsrHi;
  logic [NIB_W-1:0]  iirHi;
  logic [NIB_W-1:0]  iirCode;
  logic              dataReady;

  assign dlab = lcr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbr <= '0; thr <= '0; dll <= '0; dlm <= '0; fcr <= '0;
      lcr <= '0; mcr <= '0; scr <= '0; msr <= '0; ier <= '0;
      lsrHi <= '0; iirHi <= '0; dataReady <= 1'b0; thrFull <= 1'b0;
      locThrIrq <= 1'b0; locRbrTaken <= 1'b0;
    end else begin
      if (strb.hostWrThr) thr <= hostWdata;
      if (strb.hostWrDll) dll <= hostWdata;
      if (strb.hostWrDlm) dlm <= hostWdata;
      if (strb.hostWrIer) ier <= hostWdata[IER_W-1:0];
      if (strb.hostWrFcr) fcr <= hostWdata;
      if (strb.hostWrLcr) lcr <= hostWdata;
      if (strb.hostWrMcr) mcr <= hostWdata;
      if (strb.hostWrScr) scr <= hostWdata;
      if (strb.locWrRbr)  rbr <= locWdata;
      if (strb.locWrLsr)  lsrHi <= locWdata[DATA_W-1:1];
      if (strb.locWrMsr)  msr <= locWdata;
      if (strb.locWrIir)  iirHi <= locWdata[DATA_W-1:NIB_W];
      if (strb.hostWrThr)     thrFull <= 1'b1;
      else if (strb.locRdThr) thrFull <= 1'b0;
      if (strb.locWrRbr)       dataReady <= 1'b1;
      else if (strb.hostRdRbr) dataReady <= 1'b0;
      locThrIrq   <= strb.hostWrThr;
      locRbrTaken <= strb.hostRdRbr;
    end
  end

  always_comb begin
    if (ier[0] && dataReady)     iirCode = 4'h4;
    else if (ier[1] && !thrFull) iirCode = 4'h2;
    else                         iirCode = 4'h1;
  end

  always_comb begin
    hostRdata = '0;
    if (strb.hostRdEn) begin
      case (hostAddr)
        3'd0: hostRdata = dlab ? dll : rbr;
        3'd1: hostRdata = dlab ? dlm : {{(DATA_W-IER_W){1'b0}}, ier};
        3'd2: hostRdata = {iirHi, iirCode};
        3'd3: hostRdata = lcr;
        3'd4: hostRdata = mcr;
        3'd5: hostRdata = {lsrHi, dataReady};
        3'd6: hostRdata = msr;
        default: hostRdata = scr;
      endcase
    end
  end

  always_comb begin
    locRdata = '0;
    if (strb.locRdEn) begin
      case (locAddr)
        3'd0: locRdata = thr;
        3'd1: locRdata = {{(DATA_W-IER_W){1'b0}}, ier};
        3'd2: locRdata = fcr;
        3'd3: locRdata = lcr;
        3'd4: locRdata = mcr;
        3'd5: locRdata = dll;
        3'd6: locRdata = dlm;
        default: locRdata = scr;
      endcase
    end
  end

  assert_thr_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thrFull) |-> $past(strb.hostWrThr));
  assert_irq_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    locThrIrq |-> thrFull);
  assert_dr_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(strb.hostRdRbr));
  assert_dr_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(strb.locWrRbr));
  assert_lcr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.hostWrLcr) |-> $stable(lcr));
endmodule

// File: rtl/uart_mimic_regs.sv
module uart_mimic_regs
  import mimic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              locWr,
  input  logic              locRd,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] locRdata,
  output logic              thrFull,
  output logic              locThrIrq,
  output logic              locRbrTaken
);
  strobe_t strb;
  logic    dlab;

  mimic_ctrl u_ctrl (
    .hostCs(hostCs), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .dlab(dlab), .locWr(locWr), .locRd(locRd), .locAddr(locAddr), .strb(strb)
  );

  mimic_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .locAddr(locAddr), .locWdata(locWdata),
    .dlab(dlab), .hostRdata(hostRdata), .locRdata(locRdata),
    .thrFull(thrFull), .locThrIrq(locThrIrq), .locRbrTaken(locRbrTaken)
  );
endmodule

// File: tb/uart_mimic_regs_tb.sv
module uart_mimic_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCs = 0, hostWr = 0, hostRd = 0;
  logic [2:0] hostAddr = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic locWr = 0, locRd = 0;
  logic [2:0] locAddr = 0;
  logic [7:0] locWdata = 0;
  logic [7:0] locRdata;
  logic thrFull, locThrIrq, locRbrTaken;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mimic_regs u_dut (
    .clk(clk), .rstN(rstN), .hostCs(hostCs), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .locWr(locWr), .locRd(locRd), .locAddr(locAddr), .locWdata(locWdata),
    .locRdata(locRdata), .thrFull(thrFull), .locThrIrq(locThrIrq),
    .locRbrTaken(locRbrTaken)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostCs = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostCs = 0; hostWr = 0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostCs = 1; hostRd = 1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostCs = 0; hostRd = 0;
  endtask

  task automatic locWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    locWr = 1; locAddr = a; locWdata = d;
    @(negedge clk);
    locWr = 0;
  endtask

  task automatic locRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    locRd = 1; locAddr = a;
    #1 d = locRdata;
    @(negedge clk);
    locRd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, w;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    hostRead(3'd2, v); chk("R1 iir", v, 8'h01);
    hostRead(3'd5, v); chk("R1 lsr", v, 8'h00);
    hostRead(3'd7, v); chk("R1 scr", v, 8'h00);
    chk("R1 thrFull", {7'd0, thrFull}, 8'h00);

    // R8 scratch sweep
    for (int i = 0; i < 256; i++) begin
      hostWrite(3'd7, i[7:0]);
      hostRead(3'd7, v); chk("R8 scr host", v, i[7:0]);
      locRead(3'd7, v);  chk("R8 scr local", v, i[7:0]);
    end

    // R2 bank switch, R8 divisor readback
    for (int i = 0; i < 8; i++) begin
      w = 8'h11 * i[7:0] + 8'h07;
      hostWrite(3'd3, 8'h80);
      hostWrite(3'd0, w);
      hostWrite(3'd1, ~w);
      hostRead(3'd0, v); chk("R2 dll", v, w);
      hostRead(3'd1, v); chk("R2 dlm", v, ~w);
      locRead(3'd5, v);  chk("R8 dll local", v, w);
      locRead(3'd6, v);  chk("R8 dlm local", v, ~w);
      chk("R2 no thr via dll", {7'd0, thrFull}, 8'h00);
      hostWrite(3'd3, 8'h03);
      hostWrite(3'd1, w);
      hostRead(3'd1, v); chk("R9 ier mask", v, {4'h0, w[3:0]});
      locRead(3'd1, v);  chk("R8 ier local", v, {4'h0, w[3:0]});
      hostRead(3'd0, v); chk("R2 rbr bank", v, 8'h00);
      hostWrite(3'd3, 8'h80);
      hostRead(3'd1, v); chk("R2 dlm kept", v, ~w);
      hostWrite(3'd3, 8'h03);
    end
    hostWrite(3'd1, 8'h00);

    // R8 fcr, lcr, mcr local readback
    hostWrite(3'd2, 8'hC7); locRead(3'd2, v); chk("R8 fcr", v, 8'hC7);
    hostWrite(3'd4, 8'h1B); locRead(3'd4, v); chk("R8 mcr", v, 8'h1B);
    hostRead(3'd4, v); chk("R8 mcr host", v, 8'h1B);
    locRead(3'd3, v); chk("R8 lcr", v, 8'h03);

    // R3 transmit path
    for (int i = 0; i < 4; i++) begin
      w = 8'hA5 ^ (i[7:0] << 2);
      hostWrite(3'd0, w);
      chk("R3 irq pulse", {7'd0, locThrIrq}, 8'h01);
      chk("R3 thrFull set", {7'd0, thrFull}, 8'h01);
      @(negedge clk);
      chk("R3 irq one cycle", {7'd0, locThrIrq}, 8'h00);
      locRead(3'd0, v); chk("R3 thr data", v, w);
      chk("R3 thrFull clear", {7'd0, thrFull}, 8'h00);
    end

    // R4 receive path
    for (int i = 0; i < 4; i++) begin
      w = 8'h3C + i[7:0];
      locWrite(3'd0, w);
      hostRead(3'd5, v); chk("R4 dr set", v, 8'h01);
      hostRead(3'd0, v); chk("R4 rbr data", v, w);
      chk("R4 taken pulse", {7'd0, locRbrTaken}, 8'h01);
      hostRead(3'd5, v); chk("R4 dr clear", v, 8'h00);
      chk("R4 taken one cycle", {7'd0, locRbrTaken}, 8'h00);
    end

    // R5 interrupt identification sweep
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 2; d++) begin
        for (int t = 0; t < 2; t++) begin
          logic [3:0] code;
          logic [3:0] hi;
          hi = 4'(e * 4 + d * 2 + t);
          hostRead(3'd0, v);
          locRead(3'd0, v);
          hostWrite(3'd1, 8'(e));
          locWrite(3'd3, {hi, 4'hF});
          if (d == 1) locWrite(3'd0, 8'h99);
          if (t == 1) hostWrite(3'd0, 8'h42);
          if (e[0] && d == 1)      code = 4'h4;
          else if (e[1] && t == 0) code = 4'h2;
          else                     code = 4'h1;
          hostRead(3'd2, v); chk("R5 iir", v, {hi, code});
        end
      end
    end
    hostRead(3'd0, v); locRead(3'd0, v);
    hostWrite(3'd1, 8'h00);

    // R6 chip select
    hostWrite(3'd7, 8'h5A);
    @(negedge clk); hostWr = 1; hostAddr = 3'd7; hostWdata = 8'hFF;
    #1 chk("R6 rdata idle", hostRdata, 8'h00);
    @(negedge clk); hostWr = 0; hostRd = 1;
    #1 chk("R6 rdata no cs", hostRdata, 8'h00);
    @(negedge clk); hostRd = 0; hostWr = 1; hostAddr = 3'd0; hostWdata = 8'h77;
    @(negedge clk); hostWr = 0;
    chk("R6 no thr", {7'd0, thrFull}, 8'h00);
    hostRead(3'd7, v); chk("R6 scr kept", v, 8'h5A);

    // R7 line and modem status
    locWrite(3'd1, 8'hE1);
    locWrite(3'd2, 8'hB4);
    hostWrite(3'd5, 8'h00);
    hostWrite(3'd6, 8'h00);
    hostRead(3'd5, v); chk("R7 lsr", v, 8'hE0);
    hostRead(3'd6, v); chk("R7 msr", v, 8'hB4);

    // R10 set wins over clear in the same cycle
    locWrite(3'd0, 8'h10);
    @(negedge clk);
    hostCs = 1; hostRd = 1; hostAddr = 3'd0; locWr = 1; locAddr = 3'd0; locWdata = 8'h20;
    @(negedge clk);
    hostCs = 0; hostRd = 0; locWr = 0;
    hostRead(3'd5, v); chk("R10 dr kept", v, 8'hE1);
    hostRead(3'd0, v); chk("R10 rbr new", v, 8'h20);
    hostWrite(3'd0, 8'h31);
    @(negedge clk);
    hostCs = 1; hostWr = 1; hostAddr = 3'd0; hostWdata = 8'h32; locRd = 1; locAddr = 3'd0;
    @(negedge clk);
    hostCs = 0; hostWr = 0; locRd = 0;
    chk("R10 thrFull kept", {7'd0, thrFull}, 8'h01);
    locRead(3'd0, v); chk("R10 thr new", v, 8'h32);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule